// File: doc/BRIEF.md
# Indexed Codec Control Register File

This block is the host-facing control store of an audio codec. A byte-wide host bus reaches four direct ports: an index pointer, a data window, an interrupt status byte and a programmed-I/O data byte. The data window opens onto 32 indirect 8-bit control registers. The register picked is set by the index pointer. A mode bit decides whether the pointer selects among 16 or 32 registers.

The block keeps the reset image of every register. It applies the per-register write rules: read-only and reserved slots, single-bit fields, and a forced-zero bit. It lets the sample-format register change only while a mode-change permit is open. It also keeps the interrupt flag and its clearing paths, and it produces a calibration-busy flag that shows for a fixed number of reads after a mode-change permit opens. An `irq_evt` pulse from the playback engine raises the interrupt. The audio datapath, its transfer engine and the mixer analogue functions are outside the block; it only holds their settings.

A host access is one cycle with `acc_en` high. Read data is combinational from the current state. Side effects take place at the closing clock edge: writes, and the counter step caused by reading the calibration slot.

Top module: `codec_ctrl_regs`

## Requirements
- R1: After reset the index pointer reads 0x40 and the status byte reads 0x00. The indirect slots reset as follows: slots 2, 3, 4, 5, 18 and 19 to 0x88; slots 6 and 7 to 0x80; slot 9 to 0x08; slot 12 to 0x8A; slots 25 and 26 to 0xA0; every other slot to 0x00. `irq_o` is low after reset.
- R2: A write to port 0 stores the byte with bit 7 forced to 0. A read of port 0 returns the stored byte. A data-port write to any ordinary slot stores the byte exactly as written.
- R3: When bit 6 of slot 12 is 0, the data port selects the slot given by bits 3:0 of the index pointer. When that bit is 1, it uses bits 4:0.
- R4: A write to slot 8 (format) while bit 6 of the index pointer (the mode-change permit) is 1 stores the whole byte.
- R5: When the mode-change permit is 0, a write to slot 8 is handled by bit 4 of slot 24 (the playback-change permit). If that bit is 1, the write updates bits 7:4 and keeps bits 3:0. If it is 0, the write is dropped.
- R6: Writes to slots 11, 22, 27 and 29 change nothing.
- R7: A write to slot 12 changes only its bit 6. A write to slot 9 always stores bit 5 as 0.
- R8: A port-0 write can move the index pointer's bit 6 from 0 to 1. If that happens while bits 4:3 of slot 9 are not both 0, a counter is loaded with CAL_LOAD (default 1). Each read of slot 11 while the counter is nonzero returns bit 5 set and decrements the counter. Reads of other slots leave the counter alone.
- R9: An `irq_evt` pulse sets status bit 0 and bit 4 of slot 24. `irq_o` is a registered level equal to status bit 0, high from the edge that takes the pulse.
- R10: Any write to port 2 clears status bit 0, `irq_o` and bits 6:4 of slot 24. An `irq_evt` in the same cycle wins and leaves the flag set.
- R11: A data-port write to slot 24 with bit 4 at 0 clears status bit 0 and `irq_o` when slot 24 bit 4 was 1 before the write. The same write with bit 4 at 1 leaves the interrupt set.
- R12: Port 3 reads 0x00 and ignores writes. Port 2 reads bit 0 as the interrupt flag and bits 7:1 as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_en | input | 1 | Host access strobe, one cycle per access |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 2 | Direct port select: 0 index, 1 data, 2 status, 3 PIO |
| acc_wdata | input | 8 | Write byte |
| acc_rdata | output | 8 | Read byte for the addressed port (combinational) |
| irq_evt | input | 1 | Playback terminal-count pulse that raises the interrupt |
| irq_o | output | 1 | Interrupt request level |

## Verification
The hardest state to reach is the calibration window. Opening it needs three steps in order: slot 9 must hold nonzero bits 4:3, the permit bit must be cleared, and the permit bit must then be set by an index write. The bench builds that sequence, and a repeat without the slot-9 bits. It then reads a different slot and re-points at slot 11 with the permit already open, to show that only a read of slot 11 uses up the count and that no reload happens. A second hard case is an interrupt event in the same cycle as a status-port write. The bench drives both in one cycle.

// File: rtl/ccr_pkg.sv
// Package: shared constants, reset image and write rules of the codec
// control register file. Assumes byte-wide registers.
package ccr_pkg;

    localparam int unsigned BYTE_W = 8;

    // Direct port offsets decoded from the host address
    localparam logic [1:0] PORT_INDEX  = 2'd0;
    localparam logic [1:0] PORT_DATA   = 2'd1;
    localparam logic [1:0] PORT_STATUS = 2'd2;
    localparam logic [1:0] PORT_PIO    = 2'd3;

    // Indirect slots with special behaviour
    localparam int SLOT_FORMAT  = 8;
    localparam int SLOT_IFCFG   = 9;
    localparam int SLOT_CALSTAT = 11;
    localparam int SLOT_MODEID  = 12;
    localparam int SLOT_FLAGS   = 24;

    // Bit positions used by neighbouring logic
    localparam int BIT_PERMIT   = 6;   // index pointer: mode-change permit
    localparam int BIT_WIDE     = 6;   // slot 12: wide index
    localparam int BIT_PBPERMIT = 4;   // slot 24: playback-change permit / pending flag
    localparam int BIT_CALBUSY  = 5;   // slot 11: calibration busy on read

    localparam logic [BYTE_W-1:0] INDEX_RESET = 8'h40;
    localparam logic [BYTE_W-1:0] PIO_VALUE   = 8'h00;

    // Reset image of one indirect slot
    function automatic logic [BYTE_W-1:0] slot_reset(input int idx);
        case (idx)
            2, 3, 4, 5, 18, 19: slot_reset = 8'h88;
            6, 7:               slot_reset = 8'h80;
            SLOT_IFCFG:         slot_reset = 8'h08;
            SLOT_MODEID:        slot_reset = 8'h8A;
            25, 26:             slot_reset = 8'hA0;
            default:            slot_reset = 8'h00;
        endcase
    endfunction

    // Value a slot takes when the host writes it through the data port
    function automatic logic [BYTE_W-1:0] slot_write(
        input int                idx,
        input logic [BYTE_W-1:0] old,
        input logic [BYTE_W-1:0] din,
        input logic              permit,
        input logic              pb_permit
    );
        case (idx)
            SLOT_FORMAT: begin
                if (permit)         slot_write = din;
                else if (pb_permit) slot_write = {din[7:4], old[3:0]};
                else                slot_write = old;
            end
            SLOT_IFCFG:                     slot_write = din & 8'hDF;
            SLOT_CALSTAT, 22, 27, 29:       slot_write = old;
            SLOT_MODEID: begin
                slot_write = old;
                slot_write[BIT_WIDE] = din[BIT_WIDE];
            end
            default:                        slot_write = din;
        endcase
    endfunction

endpackage

// File: rtl/ccr_index_unit.sv
// Module: index pointer, slot decode and calibration-busy counter.
// Assumes at most one host access per cycle; the counter is loaded only
// on a 0->1 move of the permit bit made by a port-0 write.
module ccr_index_unit
    import ccr_pkg::*;
#(
    parameter int NREG     = 32,
    parameter int CAL_LOAD = 1,
    localparam int IW      = $clog2(NREG),
    localparam int CAL_W   = (CAL_LOAD < 2) ? 1 : $clog2(CAL_LOAD + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              idx_wr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              cal_arm,
    input  logic              cal_read,
    input  logic              wide,
    output logic [BYTE_W-1:0] idx_q,
    output logic [IW-1:0]     slot_sel,
    output logic              cal_active,
    output logic [CAL_W-1:0]  cal_cnt
);

    localparam logic [CAL_W-1:0] CAL_INIT = CAL_W'(CAL_LOAD);

    logic permit_rise;

    // Detect a port-0 write that opens the mode-change permit
    always_comb permit_rise = idx_wr && !idx_q[BIT_PERMIT] && wdata[BIT_PERMIT];

    // Index pointer register, bit 7 never stored
    always_ff @(posedge clk) begin
        if (!rst_n)      idx_q <= INDEX_RESET;
        else if (idx_wr) idx_q <= {1'b0, wdata[BYTE_W-2:0]};
    end

    // Slot decode: narrow or wide by the mode bit
    always_comb begin
        slot_sel = idx_q[IW-1:0];
        if (!wide) slot_sel[IW-1] = 1'b0;
    end

    // Calibration-busy read counter
    always_ff @(posedge clk) begin
        if (!rst_n)                        cal_cnt <= '0;
        else if (permit_rise && cal_arm)   cal_cnt <= CAL_INIT;
        else if (cal_read && cal_active)   cal_cnt <= cal_cnt - 1'b1;
    end

    // Busy while count remains
    always_comb cal_active = (cal_cnt != '0);

endmodule

// File: rtl/ccr_slot_file.sv
// Module: array of indirect control slots with per-slot write rules.
// Assumes the event and status-clear inputs are single-cycle pulses; on
// slot 24 an event is applied after a clear or a host write.
module ccr_slot_file
    import ccr_pkg::*;
#(
    parameter int NREG = 32,
    localparam int IW  = $clog2(NREG)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [IW-1:0]          wr_sel,
    input  logic [BYTE_W-1:0]      wr_data,
    input  logic                   permit,
    input  logic                   stat_clr,
    input  logic                   evt,
    output logic [NREG*BYTE_W-1:0] slots_flat,
    output logic                   pend_drop
);

    logic [BYTE_W-1:0] slot_q [NREG];
    logic              pb_permit;

    // Playback-change permit read from the flag slot
    always_comb pb_permit = slot_q[SLOT_FLAGS][BIT_PBPERMIT];

    // A host write that drops a pending playback flag
    always_comb pend_drop = wr_en && (wr_sel == IW'(SLOT_FLAGS))
                            && pb_permit && !wr_data[BIT_PBPERMIT];

    for (genvar i = 0; i < NREG; i++) begin : g_slot
        logic [BYTE_W-1:0] nxt;

        // Next value: host write rules, then flag-slot side paths
        always_comb begin
            nxt = slot_q[i];
            if (wr_en && wr_sel == IW'(i))
                nxt = slot_write(i, slot_q[i], wr_data, permit, pb_permit);
            if (i == SLOT_FLAGS) begin
                if (stat_clr) nxt[6:4] = 3'b000;
                if (evt)      nxt[BIT_PBPERMIT] = 1'b1;
            end
        end

        // Slot storage with its reset image
        always_ff @(posedge clk) begin
            if (!rst_n) slot_q[i] <= slot_reset(i);
            else        slot_q[i] <= nxt;
        end

        // Flatten for the read mux
        always_comb slots_flat[i*BYTE_W +: BYTE_W] = slot_q[i];
    end

endmodule

// File: rtl/ccr_irq_status.sv
// Module: interrupt status flag and request output.
// Assumes a raise event has priority over every clear in the same cycle.
module ccr_irq_status (
    input  logic clk,
    input  logic rst_n,
    input  logic raise,
    input  logic clear,
    output logic int_q
);

    // Interrupt flag: set on event, else cleared on request
    always_ff @(posedge clk) begin
        if (!rst_n)     int_q <= 1'b0;
        else if (raise) int_q <= 1'b1;
        else if (clear) int_q <= 1'b0;
    end

endmodule

// File: rtl/codec_ctrl_regs.sv
// Module: top of the codec control register file. Decodes the four direct
// host ports and forms read data. Assumes one access per acc_en cycle;
// read data is combinational and read side effects land at the clock edge.
module codec_ctrl_regs
    import ccr_pkg::*;
#(
    parameter int NREG     = 32,
    parameter int CAL_LOAD = 1,
    localparam int IW      = $clog2(NREG),
    localparam int CAL_W   = (CAL_LOAD < 2) ? 1 : $clog2(CAL_LOAD + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_en,
    input  logic              acc_wr,
    input  logic [1:0]        acc_addr,
    input  logic [BYTE_W-1:0] acc_wdata,
    output logic [BYTE_W-1:0] acc_rdata,
    input  logic              irq_evt,
    output logic              irq_o
);

    logic                   wr_index, wr_data, wr_status, rd_data;
    logic [BYTE_W-1:0]      idx_q;
    logic [IW-1:0]          slot_sel;
    logic                   cal_active, cal_read, cal_arm;
    logic [CAL_W-1:0]       cal_cnt;
    logic [NREG*BYTE_W-1:0] slots_flat;
    logic                   pend_drop, int_q;
    logic [BYTE_W-1:0]      sel_slot, ifcfg, modeid;

    // Direct port decode
    always_comb begin
        wr_index  = acc_en &&  acc_wr && (acc_addr == PORT_INDEX);
        wr_data   = acc_en &&  acc_wr && (acc_addr == PORT_DATA);
        wr_status = acc_en &&  acc_wr && (acc_addr == PORT_STATUS);
        rd_data   = acc_en && !acc_wr && (acc_addr == PORT_DATA);
    end

    // Slots feeding the index unit
    always_comb begin
        ifcfg    = slots_flat[SLOT_IFCFG*BYTE_W +: BYTE_W];
        modeid   = slots_flat[SLOT_MODEID*BYTE_W +: BYTE_W];
        sel_slot = slots_flat[slot_sel*BYTE_W +: BYTE_W];
        cal_arm  = (ifcfg[4:3] != 2'b00);
        cal_read = rd_data && (slot_sel == IW'(SLOT_CALSTAT));
    end

    ccr_index_unit #(.NREG(NREG), .CAL_LOAD(CAL_LOAD)) u_index (
        .clk        (clk),
        .rst_n      (rst_n),
        .idx_wr     (wr_index),
        .wdata      (acc_wdata),
        .cal_arm    (cal_arm),
        .cal_read   (cal_read),
        .wide       (modeid[BIT_WIDE]),
        .idx_q      (idx_q),
        .slot_sel   (slot_sel),
        .cal_active (cal_active),
        .cal_cnt    (cal_cnt)
    );

    ccr_slot_file #(.NREG(NREG)) u_slots (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_data),
        .wr_sel     (slot_sel),
        .wr_data    (acc_wdata),
        .permit     (idx_q[BIT_PERMIT]),
        .stat_clr   (wr_status),
        .evt        (irq_evt),
        .slots_flat (slots_flat),
        .pend_drop  (pend_drop)
    );

    ccr_irq_status u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .raise (irq_evt),
        .clear (wr_status || pend_drop),
        .int_q (int_q)
    );

    // Interrupt request follows the registered status flag
    always_comb irq_o = int_q;

    // Read data mux over the direct ports
    always_comb begin
        case (acc_addr)
            PORT_INDEX:  acc_rdata = idx_q;
            PORT_DATA: begin
                acc_rdata = sel_slot;
                if (cal_active && slot_sel == IW'(SLOT_CALSTAT))
                    acc_rdata[BIT_CALBUSY] = 1'b1;
            end
            PORT_STATUS: acc_rdata = {{(BYTE_W-1){1'b0}}, int_q};
            default:     acc_rdata = PIO_VALUE;
        endcase
    end

endmodule

// File: rtl/ccr_checker.sv
// Module: temporal checks for codec_ctrl_regs, attached by bind.
module ccr_checker
    import ccr_pkg::*;
#(
    parameter int NREG  = 32,
    parameter int CAL_W = 1
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   acc_en,
    input logic                   acc_wr,
    input logic [1:0]             acc_addr,
    input logic [BYTE_W-1:0]      acc_wdata,
    input logic [BYTE_W-1:0]      acc_rdata,
    input logic                   irq_evt,
    input logic                   irq_o,
    input logic [BYTE_W-1:0]      idx_q,
    input logic [CAL_W-1:0]       cal_cnt,
    input logic [NREG*BYTE_W-1:0] slots_flat
);

    logic [BYTE_W-1:0] flags, modeid;
    logic [4:0]        cur;
    logic              dwr, drd, swr, iwr;

    // Observed slots and current decode
    always_comb begin
        flags  = slots_flat[SLOT_FLAGS*BYTE_W +: BYTE_W];
        modeid = slots_flat[SLOT_MODEID*BYTE_W +: BYTE_W];
        cur    = modeid[BIT_WIDE] ? idx_q[4:0] : {1'b0, idx_q[3:0]};
        iwr    = acc_en &&  acc_wr && acc_addr == PORT_INDEX;
        dwr    = acc_en &&  acc_wr && acc_addr == PORT_DATA;
        drd    = acc_en && !acc_wr && acc_addr == PORT_DATA;
        swr    = acc_en &&  acc_wr && acc_addr == PORT_STATUS;
    end

    // R2
    idx_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        iwr |=> idx_q == {1'b0, $past(acc_wdata[6:0])});

    // R6
    locked_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dwr && !irq_evt && (cur == 5'd11 || cur == 5'd22 || cur == 5'd27 || cur == 5'd29))
        |=> $stable(slots_flat));

    // R7
    mode_bit_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dwr && cur == 5'd12) |=> ($stable(modeid[7]) && $stable(modeid[5:0])));

    // R8
    cal_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (drd && cur == 5'd11 && cal_cnt != '0) |=> cal_cnt == $past(cal_cnt) - 1'b1);

    // R9
    evt_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_evt |=> (irq_o && flags[4]));

    // R10
    status_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (swr && !irq_evt) |=> (!irq_o && flags[6:4] == 3'b000));

    // R12
    status_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_addr == PORT_STATUS) |-> acc_rdata == {7'b0, irq_o});

    // R12
    pio_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_addr == PORT_PIO) |-> acc_rdata == 8'h00);

endmodule

bind codec_ctrl_regs ccr_checker #(.NREG(NREG), .CAL_W(CAL_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc_en     (acc_en),
    .acc_wr     (acc_wr),
    .acc_addr   (acc_addr),
    .acc_wdata  (acc_wdata),
    .acc_rdata  (acc_rdata),
    .irq_evt    (irq_evt),
    .irq_o      (irq_o),
    .idx_q      (idx_q),
    .cal_cnt    (cal_cnt),
    .slots_flat (slots_flat)
);

// File: tb/codec_ctrl_regs_test.sv
`timescale 1ns/1ps
module codec_ctrl_regs_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       acc_en = 1'b0, acc_wr = 1'b0, irq_evt = 1'b0;
    logic [1:0] acc_addr = 2'd0;
    logic [7:0] acc_wdata = 8'h00;
    logic [7:0] acc_rdata;
    logic       irq_o;

    int n_cmp = 0, n_bad = 0;
    bit done = 0;

    // Requirement model
    logic [7:0] m_slot [32];
    logic [7:0] m_idx;
    logic       m_int;
    int         m_cal;

    always #10 clk = ~clk;

    codec_ctrl_regs uut (
        .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr),
        .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
        .irq_evt(irq_evt), .irq_o(irq_o)
    );

    function automatic logic [7:0] rst_img(input int i);
        if (i >= 2 && i <= 5) return 8'h88;
        if (i == 18 || i == 19) return 8'h88;
        if (i == 6 || i == 7) return 8'h80;
        if (i == 9) return 8'h08;
        if (i == 12) return 8'h8A;
        if (i == 25 || i == 26) return 8'hA0;
        return 8'h00;
    endfunction

    function automatic int m_sel();
        return (m_slot[12][6]) ? int'(m_idx & 8'h1F) : int'(m_idx & 8'h0F);
    endfunction

    function automatic void m_write(input logic [1:0] a, input logic [7:0] d);
        int s;
        logic [7:0] o;
        case (a)
            2'd0: begin
                if (!m_idx[6] && d[6] && (m_slot[9] & 8'h18) != 0) m_cal = 1;
                m_idx = d & 8'h7F;
            end
            2'd1: begin
                s = m_sel();
                o = m_slot[s];
                if (s == 8) begin
                    if (m_idx[6]) m_slot[8] = d;
                    else if (m_slot[24][4]) m_slot[8] = (d & 8'hF0) | (o & 8'h0F);
                end else if (s == 9) m_slot[9] = d & 8'hDF;
                else if (s == 12) m_slot[12] = (o & 8'hBF) | (d & 8'h40);
                else if (s == 11 || s == 22 || s == 27 || s == 29) ;
                else m_slot[s] = d;
                if (s == 24 && o[4] && !d[4]) m_int = 0;
            end
            2'd2: begin
                m_int = 0;
                m_slot[24] = m_slot[24] & 8'h8F;
            end
            default: ;
        endcase
    endfunction

    function automatic logic [7:0] m_read(input logic [1:0] a);
        int s;
        logic [7:0] v;
        case (a)
            2'd0: v = m_idx;
            2'd1: begin
                s = m_sel();
                v = m_slot[s];
                if (s == 11 && m_cal > 0) begin
                    v = v | 8'h20;
                    m_cal = m_cal - 1;
                end
            end
            2'd2: v = {7'b0, m_int};
            default: v = 8'h00;
        endcase
        return v;
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=0x%02h expected=0x%02h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
        m_write(a, d);
        @(negedge clk);
        acc_en = 1; acc_wr = 1; acc_addr = a; acc_wdata = d;
        @(posedge clk); #1;
        acc_en = 0; acc_wr = 0;
    endtask

    task automatic bus_rd(input logic [1:0] a, input string tag);
        logic [7:0] e;
        e = m_read(a);
        @(negedge clk);
        acc_en = 1; acc_wr = 0; acc_addr = a;
        #2 check(tag, acc_rdata, e);
        @(posedge clk); #1;
        acc_en = 0;
    endtask

    task automatic chk_irq(input string tag);
        @(negedge clk);
        #2 check(tag, {7'b0, irq_o}, {7'b0, m_int});
    endtask

    task automatic pulse_evt(input bit with_status);
        if (with_status) m_write(2'd2, 8'h00);
        m_int = 1;
        m_slot[24] = m_slot[24] | 8'h10;
        @(negedge clk);
        irq_evt = 1;
        if (with_status) begin
            acc_en = 1; acc_wr = 1; acc_addr = 2'd2; acc_wdata = 8'h00;
        end
        @(posedge clk); #1;
        irq_evt = 0; acc_en = 0; acc_wr = 0;
    endtask

    function automatic string sweep_tag(input int i);
        if (i == 8) return "R4";
        if (i == 11 || i == 22 || i == 27 || i == 29) return "R6";
        if (i == 9 || i == 12) return "R7";
        return "R2";
    endfunction

    initial begin
        for (int i = 0; i < 32; i++) m_slot[i] = rst_img(i);
        m_idx = 8'h40; m_int = 0; m_cal = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;

        // R1: reset image, narrow range first, then wide range
        bus_rd(2'd0, "R1");
        bus_rd(2'd2, "R1");
        chk_irq("R1");
        for (int i = 0; i < 16; i++) begin
            bus_wr(2'd0, 8'h40 | 8'(i));
            bus_rd(2'd1, "R1");
        end
        bus_wr(2'd0, 8'h4C);
        bus_wr(2'd1, 8'h40);
        for (int i = 16; i < 32; i++) begin
            bus_wr(2'd0, 8'h40 | 8'(i));
            bus_rd(2'd1, "R1");
        end

        // R3: wide write to slot 18, then narrow decode lands on slot 2
        bus_wr(2'd0, 8'h52);
        bus_wr(2'd1, 8'h33);
        bus_wr(2'd0, 8'h4C);
        bus_wr(2'd1, 8'h00);
        bus_wr(2'd0, 8'h52);
        bus_rd(2'd1, "R3");
        bus_wr(2'd0, 8'h4C);
        bus_wr(2'd1, 8'h40);
        bus_wr(2'd0, 8'h52);
        bus_rd(2'd1, "R3");

        // R2: index store drops bit 7
        bus_wr(2'd0, 8'hD5);
        bus_rd(2'd0, "R2");

        // R2 R4 R6 R7: write/read sweep over all slots with permit open
        for (int i = 0; i < 32; i++) begin
            logic [7:0] d;
            d = 8'((i * 53 + 17) ^ 8'hA6);
            if (i == 12) d = d | 8'h40;
            bus_wr(2'd0, 8'h40 | 8'(i));
            bus_wr(2'd1, d);
            bus_rd(2'd1, sweep_tag(i));
        end

        // R5: format gating with permit closed
        bus_wr(2'd0, 8'h18);
        bus_wr(2'd1, 8'h00);
        bus_wr(2'd0, 8'h08);
        bus_wr(2'd1, 8'hFF);
        bus_rd(2'd1, "R5");
        bus_wr(2'd0, 8'h18);
        bus_wr(2'd1, 8'h10);
        bus_wr(2'd0, 8'h08);
        bus_wr(2'd1, 8'hA5);
        bus_rd(2'd1, "R5");
        bus_wr(2'd0, 8'h48);
        bus_wr(2'd1, 8'h3C);
        bus_rd(2'd1, "R4");

        // R8: calibration busy window
        bus_wr(2'd0, 8'h09);
        bus_wr(2'd1, 8'h18);
        bus_wr(2'd0, 8'h4B);
        bus_rd(2'd1, "R8");
        bus_rd(2'd1, "R8");
        bus_wr(2'd0, 8'h09);
        bus_wr(2'd1, 8'h00);
        bus_wr(2'd0, 8'h0B);
        bus_wr(2'd0, 8'h4B);
        bus_rd(2'd1, "R8");
        bus_wr(2'd0, 8'h09);
        bus_wr(2'd1, 8'h08);
        bus_wr(2'd0, 8'h0C);
        bus_wr(2'd0, 8'h4C);
        bus_rd(2'd1, "R8");
        bus_wr(2'd0, 8'h4B);
        bus_rd(2'd1, "R8");
        bus_rd(2'd1, "R8");

        // R9: event raises flag and slot 24 bit 4
        bus_wr(2'd0, 8'h58);
        bus_wr(2'd1, 8'h00);
        pulse_evt(0);
        chk_irq("R9");
        bus_rd(2'd2, "R9");
        bus_rd(2'd1, "R9");

        // R10: status write clears
        bus_wr(2'd1, 8'h70);
        bus_wr(2'd2, 8'h5A);
        chk_irq("R10");
        bus_rd(2'd1, "R10");

        // R11: slot 24 bit 4 falling clears, keeping it set does not
        pulse_evt(0);
        bus_wr(2'd1, 8'h10);
        chk_irq("R11");
        bus_wr(2'd1, 8'h00);
        chk_irq("R11");

        // R10: event beats a same-cycle status write
        pulse_evt(1);
        chk_irq("R10");
        bus_rd(2'd1, "R10");
        bus_wr(2'd2, 8'h00);
        chk_irq("R10");

        // R12: PIO port and status read
        bus_wr(2'd3, 8'hFF);
        bus_rd(2'd3, "R12");
        bus_rd(2'd2, "R12");
        pulse_evt(0);
        bus_rd(2'd2, "R12");
        bus_rd(2'd3, "R12");

        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule